// File: doc/BRIEF.md
# Resolution-Configurable Bitstream Decimator

This block is a first-order cascaded integrator-comb decimation filter. Its input is the one-bit, noise-shaped, oversampled stream that a sigma-delta modulator produces. It turns that stream into signed parallel words at a lower rate. It needs no multipliers. The integrator counts the ones that arrive in a window of 2^b valid samples. The comb stage has a differential delay of one, so it reduces to dumping that count and clearing the accumulator at the end of each window.

A 3-bit select sets the window length and the output resolution together. Code k gives b = k + 5 bits and a decimation ratio of 2^b, which covers 32 to 4096. The b-bit count is saturated and converted from offset binary to two's complement. It is then sign-extended onto a 12-bit output bus whose MSB is the sign bit.

A three-state controller sequences the block:
- PRIME: the single cycle after reset, where the select is captured.
- FILL: accumulating samples.
- EMIT: the one cycle in which a new word is presented.

The transitions are:
- reset → PRIME from any state.
- PRIME → FILL, unconditionally.
- FILL → FILL while the frame is incomplete.
- FILL → EMIT when the final sample of a frame is taken.
- EMIT → FILL on the next cycle. The window is at least 32 samples long, so EMIT → EMIT cannot occur.

Top module: `sdm_cic_decimator`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `pcm_vld` is 0 and `pcm_word` is 0.
- R2: Select code k (0..7) makes a frame exactly 2^(k+5) valid samples long, so the ratio runs from 32 (k=0) to 4096 (k=7).
- R3: At the end of a frame, the word is min(N, 2^b−1) − 2^(b−1). Here N is the number of ones in the frame. The word is in two's complement, sign-extended to 12 bits, with bit 11 as the sign.
- R4: A frame of all ones saturates to 2^(b−1)−1, for example 15 for b=5 and 2047 for b=12.
- R5: A frame of all zeros gives −2^(b−1), for example 12'hFF0 for b=5.
- R6: Cycles with `sd_vld` low are neither counted toward the frame length nor accumulated.
- R7: `pcm_vld` is high for exactly one cycle, in the cycle after the clock edge that takes a frame's final sample. `pcm_word` changes only at that edge and holds its value until the next pulse.
- R8: `res_sel` is captured only at a frame boundary (the edge of a frame's final sample) and in the PRIME cycle. Changing it mid-frame does not alter the current frame. The captured value sets the length of the next frame, which starts from an empty accumulator.
- R9: In the PRIME cycle after reset, an input sample is ignored even if `sd_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sd_bit | input | 1 | Modulator output bit |
| sd_vld | input | 1 | Qualifies `sd_bit` for this cycle |
| res_sel | input | 3 | Resolution/ratio code k, b = k + 5 |
| pcm_word | output | 12 | Two's-complement decimated word, sign-extended |
| pcm_vld | output | 1 | One-cycle pulse marking a new word |

## Verification
The checks assume the following about the inputs:
- `rst` is high at the first clock edge.
- Reset is the only thing that interrupts a frame.
- The select code is any 3-bit value; it may change on any cycle.

From these assumptions, the checker holds two properties:
- Each pulse follows a power-of-two count of accepted samples between 32 and 4096.
- The signed word lies within half that count on either side of zero.

The stimulus drives the select freely in the middle of frames to exercise the boundary capture. It also inserts idle cycles, places a set input bit in the PRIME cycle, and cuts one frame short with a reset.

// File: rtl/cic_pkg.sv
package cic_pkg;
    // Controller phases: capture select, accumulate, present word.
    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_FILL  = 2'd1,
        ST_EMIT  = 2'd2
    } phase_t;
endpackage

// File: rtl/cic_frame_fsm.sv
module cic_frame_fsm
    import cic_pkg::*;
#(
    parameter int MIN_BITS = 5,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic [SEL_W-1:0] sel_in,
    output phase_t           phase,
    output logic [SEL_W-1:0] act_sel,
    output logic             take,
    output logic             last
);
    localparam int NUM_SEL = 1 << SEL_W;
    localparam int CNT_W   = MIN_BITS + NUM_SEL - 1;

    phase_t           phase_q;
    phase_t           phase_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top_tbl [NUM_SEL];

    // Terminal sample index for each ratio code.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_top
        assign top_tbl[g] = CNT_W'((64'd1 << (MIN_BITS + g)) - 64'd1);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= ST_PRIME;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Next-state logic.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            ST_PRIME: phase_d = ST_FILL;
            ST_FILL:  phase_d = last ? ST_EMIT : ST_FILL;
            ST_EMIT:  phase_d = last ? ST_EMIT : ST_FILL;
            default:  phase_d = ST_PRIME;
        endcase
    end

    // Output decode.
    always_comb begin
        take = smp_vld && (phase_q != ST_PRIME);
        last = take && (cnt_q == top_tbl[act_sel]);
    end

    // Sample counter and frame-boundary select capture.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            act_sel <= '0;
        end else if (phase_q == ST_PRIME) begin
            cnt_q   <= '0;
            act_sel <= sel_in;
        end else if (last) begin
            cnt_q   <= '0;
            act_sel <= sel_in;
        end else if (take) begin
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/cic_integrator.sv
module cic_integrator #(
    parameter int ACC_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             take,
    input  logic             last,
    input  logic             bit_in,
    output logic [ACC_W-1:0] sum
);
    logic [ACC_W-1:0] acc_q;

    // Integrator output including the bit arriving now.
    assign sum = acc_q + ACC_W'(bit_in);

    // Accumulate, and dump (clear) at the frame end: unit-delay comb.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (take) begin
            acc_q <= last ? '0 : sum;
        end
    end
endmodule

// File: rtl/cic_word_shaper.sv
module cic_word_shaper #(
    parameter int MIN_BITS = 5,
    parameter int SEL_W    = 3,
    parameter int ACC_W    = 13,
    parameter int OUT_W    = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SEL_W-1:0] act_sel,
    input  logic [ACC_W-1:0] sum,
    output logic [OUT_W-1:0] word
);
    localparam int NUM_SEL = 1 << SEL_W;

    logic [OUT_W-1:0] cand [NUM_SEL];

    // One saturate-and-convert path per resolution.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_res
        localparam int B = MIN_BITS + g;
        localparam logic [ACC_W-1:0] LIM = ACC_W'((64'd1 << B) - 64'd1);
        logic [B-1:0] code;
        assign code    = (sum > LIM) ? LIM[B-1:0] : sum[B-1:0];
        // Offset binary to two's complement: flip the MSB, then sign-extend.
        assign cand[g] = OUT_W'($signed({~code[B-1], code[B-2:0]}));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (load) begin
            word <= cand[act_sel];
        end
    end
endmodule

// File: rtl/sdm_cic_decimator.sv
module sdm_cic_decimator
    import cic_pkg::*;
#(
    parameter int  MIN_BITS = 5,
    parameter int  SEL_W    = 3,
    localparam int OUT_W    = MIN_BITS + (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sd_bit,
    input  logic             sd_vld,
    input  logic [SEL_W-1:0] res_sel,
    output logic [OUT_W-1:0] pcm_word,
    output logic             pcm_vld
);
    localparam int ACC_W = OUT_W + 1;

    phase_t           phase;
    logic [SEL_W-1:0] act_sel;
    logic             take;
    logic             last;
    logic [ACC_W-1:0] sum;

    cic_frame_fsm #(
        .MIN_BITS(MIN_BITS),
        .SEL_W   (SEL_W)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .smp_vld(sd_vld),
        .sel_in (res_sel),
        .phase  (phase),
        .act_sel(act_sel),
        .take   (take),
        .last   (last)
    );

    cic_integrator #(
        .ACC_W(ACC_W)
    ) u_int (
        .clk   (clk),
        .rst   (rst),
        .clr   (phase == ST_PRIME),
        .take  (take),
        .last  (last),
        .bit_in(sd_bit),
        .sum   (sum)
    );

    cic_word_shaper #(
        .MIN_BITS(MIN_BITS),
        .SEL_W   (SEL_W),
        .ACC_W   (ACC_W),
        .OUT_W   (OUT_W)
    ) u_shape (
        .clk    (clk),
        .rst    (rst),
        .load   (last),
        .act_sel(act_sel),
        .sum    (sum),
        .word   (pcm_word)
    );

    // Output process: a word is presented only in the EMIT phase.
    always_comb begin
        pcm_vld = (phase == ST_EMIT);
    end
endmodule

// File: rtl/sdm_cic_decimator_chk.sv
module sdm_cic_decimator_chk #(
    parameter int MIN_BITS = 5,
    parameter int SEL_W    = 3
) (
    input logic                                  clk,
    input logic                                  rst,
    input logic                                  sd_vld,
    input logic [MIN_BITS+(1<<SEL_W)-2:0]        pcm_word,
    input logic                                  pcm_vld
);
    localparam int OUT_W  = MIN_BITS + (1 << SEL_W) - 1;
    localparam int SEEN_W = OUT_W + 1;

    logic [SEEN_W-1:0] seen;
    logic              rst_q;
    int                w_val;
    int                half;

    // Accepted samples since the last pulse (the PRIME cycle is excluded).
    always_ff @(posedge clk) begin
        if (rst) begin
            seen  <= '0;
            rst_q <= 1'b1;
        end else begin
            rst_q <= 1'b0;
            if (pcm_vld) begin
                seen <= (sd_vld && !rst_q) ? SEEN_W'(1) : '0;
            end else if (sd_vld && !rst_q) begin
                seen <= seen + SEEN_W'(1);
            end
        end
    end

    always_comb begin
        w_val = int'($signed(pcm_word));
        half  = int'(seen >> 1);
    end

    // R1: reset clears the output.
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!pcm_vld && pcm_word == '0));

    // R9: nothing is presented in the PRIME cycle.
    a_r9_prime_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !pcm_vld);

    // R7: one-cycle pulse.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pcm_vld |=> !pcm_vld);

    // R7: the word holds between pulses.
    a_r7_word_hold: assert property (@(posedge clk) disable iff (rst)
        !pcm_vld |-> $stable(pcm_word));

    // R2, R6: frame length is a power of two in range, counting valid cycles only.
    a_r2_frame_pow2: assert property (@(posedge clk) disable iff (rst)
        pcm_vld |-> ($countones(seen) == 1 && seen >= SEEN_W'(1 << MIN_BITS)
                     && seen <= SEEN_W'(1 << OUT_W)));

    // R3: signed result stays within half the frame length.
    a_r3_word_range: assert property (@(posedge clk) disable iff (rst)
        pcm_vld |-> (w_val >= -half && w_val < half));
endmodule

bind sdm_cic_decimator sdm_cic_decimator_chk #(
    .MIN_BITS(MIN_BITS),
    .SEL_W   (SEL_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sd_vld  (sd_vld),
    .pcm_word(pcm_word),
    .pcm_vld (pcm_vld)
);

// File: tb/sdm_cic_decimator_test.sv
module sdm_cic_decimator_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sd_bit = 1'b0;
    logic        sd_vld = 1'b0;
    logic [2:0]  res_sel = 3'd0;
    logic [11:0] pcm_word;
    logic        pcm_vld;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdm_cic_decimator uut (
        .clk     (clk),
        .rst     (rst),
        .sd_bit  (sd_bit),
        .sd_vld  (sd_vld),
        .res_sel (res_sel),
        .pcm_word(pcm_word),
        .pcm_vld (pcm_vld)
    );

    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    // Reference model state.
    bit          m_prime;
    int          m_sel, m_cnt, m_ones, m_last_b;
    bit          exp_vld;
    logic [11:0] exp_word;
    // Observed frame length, counted from the stimulus and the pulses.
    bit          obs_skip;
    int          obs_cnt, obs_len;

    function automatic logic [11:0] conv(int ones, int b);
        int top = (1 << b) - 1;
        int v = (ones > top) ? top : ones;
        return 12'(v - (1 << (b - 1)));
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic cyc(bit b, bit v);
        sd_bit = b;
        sd_vld = v;
        @(posedge clk);
        exp_vld = 1'b0;
        if (m_prime) begin
            m_prime = 1'b0;
            m_sel   = int'(res_sel);
        end else if (v) begin
            m_cnt++;
            m_ones += int'(b);
            if (m_cnt == (1 << (m_sel + 5))) begin
                exp_vld  = 1'b1;
                exp_word = conv(m_ones, m_sel + 5);
                m_last_b = m_sel + 5;
                m_cnt    = 0;
                m_ones   = 0;
                m_sel    = int'(res_sel);
            end
        end
        if (v && !obs_skip) obs_cnt++;
        obs_skip = 1'b0;
        @(negedge clk);
        if (pcm_vld) begin
            obs_len = obs_cnt;
            obs_cnt = 0;
        end
        check(pcm_vld == exp_vld, "R7 valid pulse timing", int'(pcm_vld), int'(exp_vld));
        check(pcm_word == exp_word, "R3 word value", int'(pcm_word), int'(exp_word));
    endtask

    task automatic do_reset();
        sd_vld = 1'b0;
        rst    = 1'b1;
        repeat (3) @(negedge clk);
        check(pcm_vld == 1'b0, "R1 reset valid", int'(pcm_vld), 0);
        check(pcm_word == 12'd0, "R1 reset word", int'(pcm_word), 0);
        rst      = 1'b0;
        m_prime  = 1'b1;
        m_cnt    = 0;
        m_ones   = 0;
        exp_vld  = 1'b0;
        exp_word = 12'd0;
        obs_skip = 1'b1;
        obs_cnt  = 0;
    endtask

    // mode 0: zeros, 1: ones, otherwise random with dens percent ones.
    task automatic run_frame(int mode, int dens, bit gaps, bit sel_walk);
        do begin
            bit v;
            bit b;
            v = gaps ? ($urandom_range(3) != 0) : 1'b1;
            case (mode)
                0:       b = 1'b0;
                1:       b = 1'b1;
                default: b = ($urandom_range(99) < dens);
            endcase
            if (sel_walk && $urandom_range(15) == 0) res_sel = 3'($urandom_range(4));
            cyc(b, v);
        end while (!exp_vld);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        res_sel = 3'd0;
        do_reset();
        // R1: first cycle after release, with R9: a set bit in PRIME is ignored.
        cyc(1'b1, 1'b1);
        check(pcm_vld == 1'b0, "R1 valid low after release", int'(pcm_vld), 0);
        run_frame(0, 0, 1'b0, 1'b0);
        check(pcm_word == 12'hFF0, "R9 prime sample ignored / R5 zeros", int'(pcm_word), 'hFF0);
        check(obs_len == 32, "R9 frame length after prime", obs_len, 32);

        // R2 and R4: all-ones frames across every ratio code.
        for (int k = 0; k < 9; k++) begin
            int eb;
            res_sel = (k < 8) ? 3'(k) : 3'd0;
            run_frame(1, 0, 1'b0, 1'b0);
            eb = (k == 0) ? 5 : k + 4;
            check(obs_len == (1 << eb), "R2 frame length from select", obs_len, 1 << eb);
            check(pcm_word == 12'((1 << (eb - 1)) - 1), "R4 all-ones saturation",
                  int'(pcm_word), (1 << (eb - 1)) - 1);
        end

        // R5: all zeros at b=7.
        res_sel = 3'd2;
        run_frame(0, 0, 1'b0, 1'b0);
        run_frame(0, 0, 1'b0, 1'b0);
        check(pcm_word == 12'hFC0, "R5 all-zero minimum", int'(pcm_word), 'hFC0);

        // R6: idle cycles are not counted.
        run_frame(1, 0, 1'b1, 1'b0);
        check(obs_len == 128, "R6 idle cycles not counted", obs_len, 128);
        check(pcm_word == 12'd63, "R6 idle cycles not accumulated", int'(pcm_word), 63);

        // R8: mid-frame select changes do not affect the running frame.
        res_sel = 3'd1;
        run_frame(0, 0, 1'b0, 1'b0);
        repeat (10) cyc(1'b1, 1'b1);
        res_sel = 3'd3;
        repeat (20) cyc(1'b0, 1'b1);
        res_sel = 3'd0;
        run_frame(2, 50, 1'b0, 1'b0);
        check(obs_len == 64, "R8 select held through frame", obs_len, 64);
        run_frame(2, 50, 1'b0, 1'b0);
        check(obs_len == 32, "R8 select taken at boundary", obs_len, 32);

        // Random frames: density, idle gaps and select changes.
        for (int f = 0; f < 40; f++) begin
            run_frame(2, $urandom_range(100), 1'($urandom_range(1)), 1'b1);
            check(obs_len == (1 << m_last_b), "R2 random frame length", obs_len, 1 << m_last_b);
        end

        // R1: reset in the middle of a frame.
        res_sel = 3'd1;
        repeat (17) cyc(1'b1, 1'b1);
        res_sel = 3'd0;
        do_reset();
        cyc(1'b0, 1'b1);
        run_frame(1, 0, 1'b0, 1'b0);
        check(obs_len == 32, "R1 frame restarts after reset", obs_len, 32);
        check(pcm_word == 12'd15, "R1 accumulator cleared by reset", int'(pcm_word), 15);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule